// File: doc/BRIEF.md
# Minimal Complete Test Set Search Engine

The engine collects a detection table that relates every input vector of an n-line circuit to every fault in a list of p faults. It fills the table one entry at a time by asking an external fault-injecting evaluator whether a given vector exposes a given fault, over a simple request/response handshake. When the table is complete, any fault that no vector exposes is marked redundant and left out of the coverage goal. The engine then walks vector subsets of growing size and stops at the first size that covers every remaining fault.

For that size it reports the subset it met first, which is the lexicographically smallest covering subset of vector indices. It also reports how many subsets of that size cover the faults, and how many faults were redundant. If no subset of up to n vectors covers the faults, a fail flag is raised. A controller pulses start, serves the evaluator requests, and reads the results when done pulses.

Top module: `mts_search_engine`

## Requirements
- R1: While filling, the engine requests table entries with the vector index as the outer loop and the fault index as the inner loop, both counting up from 0. It holds req_vec and req_fault steady while req_valid is high and rsp_valid is low, and it advances only after a cycle with rsp_valid high.
- R2: redundant_count equals the number of faults whose detection column holds no 1. Those faults are excluded from the coverage test.
- R3: min_size is the smallest k, with 1 <= k <= N_LINES, for which some k-vector subset detects every non-redundant fault.
- R4: first_set holds the lexicographically first covering subset of size min_size, in ascending index order. Slot i occupies bits [i*N_LINES +: N_LINES], and slots at or above min_size read zero.
- R5: set_count equals the number of distinct covering subsets of size min_size.
- R6: When no subset of size up to N_LINES covers the faults, fail is 1 and min_size, set_count and first_set are all 0.
- R7: busy is high from the accepted start until the cycle that done pulses, done is high for exactly one cycle per run, and a start seen while busy has no effect on the run or its results.
- R8: After reset, busy, done, req_valid, fail, min_size, set_count, first_set and redundant_count are all 0.
- R9: When every fault is redundant, min_size is 1 and set_count equals 2^N_LINES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run; ignored while busy |
| req_valid | output | 1 | Table entry request pending |
| req_vec | output | N_LINES | Vector index of the pending request |
| req_fault | output | FW | Fault index of the pending request |
| rsp_valid | input | 1 | Evaluator answer for the pending request |
| rsp_detect | input | 1 | 1 when the vector exposes the fault |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at end of run |
| fail | output | 1 | No covering subset up to N_LINES vectors |
| min_size | output | SW | Size of the minimal covering subset |
| first_set | output | N_LINES*N_LINES | First covering subset, one index per slot |
| set_count | output | 2^N_LINES+1 | Number of minimal covering subsets |
| redundant_count | output | RCW | Number of faults no vector detects |

## Verification
The outcomes that are hardest to reach are the ends of the search: a run that exhausts every size without covering the faults, and a run in which every column is empty so that the first single vector already covers. Both are reached by choosing detection columns in the evaluator model. Disjoint row pairs force more vectors than lines, and all-zero columns make every fault redundant. A second start is pulsed in the middle of a fill while the evaluator answers with varying latency, and one case needs three vectors so that the walker crosses every size boundary.

// File: rtl/mts_pkg.sv
package mts_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FILL,
      ST_MASK,
      ST_SEARCH,
      ST_FINISH
   } mts_state_e;

   function automatic int unsigned width_of(input int unsigned count);
      return (count > 1) ? $clog2(count) : 1;
   endfunction

endpackage

// File: rtl/mts_table.sv
module mts_table #(
   parameter int unsigned N_LINES  = 3,
   parameter int unsigned N_FAULTS = 8,
   localparam int unsigned ROWS    = 1 << N_LINES,
   localparam int unsigned FW      = mts_pkg::width_of(N_FAULTS),
   localparam int unsigned RCW     = mts_pkg::width_of(N_FAULTS + 1)
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               clear,
   input  logic                               fill_en,
   output logic                               req_valid,
   output logic [N_LINES-1:0]                 req_vec,
   output logic [FW-1:0]                      req_fault,
   input  logic                               rsp_valid,
   input  logic                               rsp_detect,
   output logic                               fill_last,
   output logic [ROWS-1:0][N_FAULTS-1:0]      rows,
   output logic [N_FAULTS-1:0]                red_mask,
   output logic [RCW-1:0]                     red_count
);

   logic [N_LINES-1:0] row_q;
   logic [FW-1:0]      col_q;
   logic               accept;
   logic               col_end;

   assign req_valid = fill_en;
   assign req_vec   = row_q;
   assign req_fault = col_q;
   assign accept    = fill_en && rsp_valid;
   assign col_end   = (col_q == FW'(N_FAULTS - 1));
   assign fill_last = accept && col_end && (row_q == N_LINES'(ROWS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= '0;
         col_q <= '0;
         rows  <= '0;
      end else if (clear) begin
         row_q <= '0;
         col_q <= '0;
         rows  <= '0;
      end else if (accept) begin
         rows[row_q][col_q] <= rsp_detect;
         if (col_end) begin
            col_q <= '0;
            row_q <= row_q + N_LINES'(1);
         end else begin
            col_q <= col_q + FW'(1);
         end
      end
   end

   // Column OR across all vectors: empty column means redundant fault
   always_comb begin
      red_count = '0;
      for (int f = 0; f < int'(N_FAULTS); f++) begin
         logic any;
         any = 1'b0;
         for (int r = 0; r < int'(ROWS); r++) begin
            any = any | rows[r][f];
         end
         red_mask[f] = ~any;
         red_count   = red_count + RCW'(~any);
      end
   end

   // R1: request indices held until answered
   assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !rsp_valid) |=> ($stable(req_vec) && $stable(req_fault)));

endmodule

// File: rtl/mts_combo.sv
module mts_combo #(
   parameter int unsigned N_LINES = 3,
   localparam int unsigned ROWS   = 1 << N_LINES,
   localparam int unsigned SW     = mts_pkg::width_of(N_LINES + 1)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              load,
   input  logic                              step,
   input  logic                              grow,
   output logic [N_LINES-1:0][N_LINES-1:0]   idx,
   output logic [SW-1:0]                     size,
   output logic                              last_of_size
);

   logic [N_LINES-1:0][N_LINES-1:0] nxt;

   always_comb begin
      last_of_size = 1'b1;
      for (int i = 0; i < int'(N_LINES); i++) begin
         if (i < int'(size) && int'(idx[i]) != int'(ROWS) - int'(size) + i)
            last_of_size = 1'b0;
      end
   end

   // Lexicographic successor: bump rightmost movable slot, pack the rest after it
   always_comb begin
      int  piv;
      logic hit;
      piv = 0;
      hit = 1'b0;
      nxt = idx;
      for (int i = int'(N_LINES) - 1; i >= 0; i--) begin
         if (!hit && i < int'(size) &&
             int'(idx[i]) < int'(ROWS) - int'(size) + i) begin
            hit = 1'b1;
            piv = i;
         end
      end
      for (int j = 0; j < int'(N_LINES); j++) begin
         if (j >= piv)
            nxt[j] = N_LINES'(int'(idx[piv]) + 1 + (j - piv));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size <= '0;
         for (int i = 0; i < int'(N_LINES); i++) idx[i] <= N_LINES'(i);
      end else if (load || grow) begin
         size <= load ? SW'(1) : size + SW'(1);
         for (int i = 0; i < int'(N_LINES); i++) idx[i] <= N_LINES'(i);
      end else if (step) begin
         idx <= nxt;
      end
   end

   generate
      for (genvar g = 1; g < int'(N_LINES); g++) begin : g_order
         // R4: active slots stay in strictly ascending order
         assert_combo_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(size) > g) |-> (idx[g] > idx[g-1]));
      end
   endgenerate

endmodule

// File: rtl/mts_cover.sv
module mts_cover #(
   parameter int unsigned N_LINES  = 3,
   parameter int unsigned N_FAULTS = 8,
   localparam int unsigned ROWS    = 1 << N_LINES,
   localparam int unsigned SW      = mts_pkg::width_of(N_LINES + 1)
) (
   input  logic [ROWS-1:0][N_FAULTS-1:0]      rows,
   input  logic [N_FAULTS-1:0]                red_mask,
   input  logic [N_LINES-1:0][N_LINES-1:0]    idx,
   input  logic [SW-1:0]                      size,
   output logic                               covered
);

   logic [N_FAULTS-1:0] acc;

   always_comb begin
      acc = '0;
      for (int i = 0; i < int'(N_LINES); i++) begin
         if (i < int'(size)) acc = acc | rows[idx[i]];
      end
      covered = &(acc | red_mask);
   end

endmodule

// File: rtl/mts_search_engine.sv
module mts_search_engine #(
   parameter int unsigned N_LINES  = 3,
   parameter int unsigned N_FAULTS = 8,
   localparam int unsigned ROWS    = 1 << N_LINES,
   localparam int unsigned FW      = mts_pkg::width_of(N_FAULTS),
   localparam int unsigned SW      = mts_pkg::width_of(N_LINES + 1),
   localparam int unsigned CW      = ROWS + 1,
   localparam int unsigned RCW     = mts_pkg::width_of(N_FAULTS + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   output logic                          req_valid,
   output logic [N_LINES-1:0]            req_vec,
   output logic [FW-1:0]                 req_fault,
   input  logic                          rsp_valid,
   input  logic                          rsp_detect,
   output logic                          busy,
   output logic                          done,
   output logic                          fail,
   output logic [SW-1:0]                 min_size,
   output logic [N_LINES*N_LINES-1:0]    first_set,
   output logic [CW-1:0]                 set_count,
   output logic [RCW-1:0]                redundant_count
);
   import mts_pkg::*;

   generate
      if (N_LINES < 1 || N_LINES > 4) begin : g_bad_lines
         $error("N_LINES must lie in 1..4");
      end
      if (N_FAULTS < 1 || N_FAULTS > 64) begin : g_bad_faults
         $error("N_FAULTS must lie in 1..64");
      end
   endgenerate

   mts_state_e state_q;

   logic [ROWS-1:0][N_FAULTS-1:0]    rows;
   logic [N_FAULTS-1:0]              red_mask;
   logic [RCW-1:0]                   red_now;
   logic                             fill_last;
   logic [N_LINES-1:0][N_LINES-1:0]  idx;
   logic [SW-1:0]                    k;
   logic                             last_of_size;
   logic                             covered;
   logic                             found_any;
   logic                             c_load, c_step, c_grow;
   logic                             launch;
   logic [N_LINES*N_LINES-1:0]       set_flat;

   assign launch    = (state_q == ST_IDLE) && start;
   assign busy      = (state_q != ST_IDLE);
   assign done      = (state_q == ST_FINISH);
   assign found_any = covered || (set_count != '0);
   assign c_load    = (state_q == ST_MASK);
   assign c_step    = (state_q == ST_SEARCH) && !last_of_size;
   assign c_grow    = (state_q == ST_SEARCH) && last_of_size && !found_any &&
                      (k != SW'(N_LINES));

   always_comb begin
      set_flat = '0;
      for (int i = 0; i < int'(N_LINES); i++) begin
         if (i < int'(k)) set_flat[i*N_LINES +: N_LINES] = idx[i];
      end
   end

   mts_table #(.N_LINES(N_LINES), .N_FAULTS(N_FAULTS)) u_table (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (launch),
      .fill_en    (state_q == ST_FILL),
      .req_valid  (req_valid),
      .req_vec    (req_vec),
      .req_fault  (req_fault),
      .rsp_valid  (rsp_valid),
      .rsp_detect (rsp_detect),
      .fill_last  (fill_last),
      .rows       (rows),
      .red_mask   (red_mask),
      .red_count  (red_now)
   );

   mts_combo #(.N_LINES(N_LINES)) u_combo (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (c_load),
      .step         (c_step),
      .grow         (c_grow),
      .idx          (idx),
      .size         (k),
      .last_of_size (last_of_size)
   );

   mts_cover #(.N_LINES(N_LINES), .N_FAULTS(N_FAULTS)) u_cover (
      .rows     (rows),
      .red_mask (red_mask),
      .idx      (idx),
      .size     (k),
      .covered  (covered)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q         <= ST_IDLE;
         fail            <= 1'b0;
         min_size        <= '0;
         first_set       <= '0;
         set_count       <= '0;
         redundant_count <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q         <= ST_FILL;
                  fail            <= 1'b0;
                  min_size        <= '0;
                  first_set       <= '0;
                  set_count       <= '0;
                  redundant_count <= '0;
               end
            end
            ST_FILL: begin
               if (fill_last) state_q <= ST_MASK;
            end
            ST_MASK: begin
               redundant_count <= red_now;
               state_q         <= ST_SEARCH;
            end
            ST_SEARCH: begin
               if (covered) begin
                  set_count <= set_count + CW'(1);
                  if (set_count == '0) first_set <= set_flat;
               end
               if (last_of_size) begin
                  if (found_any) begin
                     min_size <= k;
                     state_q  <= ST_FINISH;
                  end else if (k == SW'(N_LINES)) begin
                     fail    <= 1'b1;
                     state_q <= ST_FINISH;
                  end
               end
            end
            ST_FINISH: state_q <= ST_IDLE;
            default:   state_q <= ST_IDLE;
         endcase
      end
   end

   // R7: run ends right after the done pulse
   assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);
   // R7: a run never drops busy before done
   assert_busy_until_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   // R6: failure reports empty results
   assert_fail_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fail) |-> (min_size == '0 && set_count == '0 && first_set == '0));
   // R3: success reports a non-zero size and count
   assert_found_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fail) |-> (min_size != '0 && set_count != '0));
   // R5: count only moves while searching
   assert_count_search_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_SEARCH && state_q != ST_IDLE) |=> $stable(set_count));

endmodule

// File: tb/mts_search_engine_bench.sv
module mts_search_engine_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 3;
   localparam int NF = 8;
   localparam int NR = 1 << NL;

   typedef struct {
      int size;
      int cnt;
      int red;
      int fl;
      int first;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        req_valid;
   logic [2:0]  req_vec;
   logic [2:0]  req_fault;
   logic        rsp_valid = 1'b0;
   logic        rsp_detect = 1'b0;
   logic        busy, done, fail;
   logic [1:0]  min_size;
   logic [8:0]  first_set;
   logic [8:0]  set_count;
   logic [3:0]  redundant_count;

   logic [NR-1:0] cols [NF];
   exp_t q[$];
   int nchk = 0;
   int nfail = 0;
   int ord = 0;
   int wcnt = 0;
   int dones = 0;
   bit ended = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mts_search_engine #(.N_LINES(NL), .N_FAULTS(NF)) u_mts_search_engine (
      .clk(clk), .rst_n(rst_n), .start(start),
      .req_valid(req_valid), .req_vec(req_vec), .req_fault(req_fault),
      .rsp_valid(rsp_valid), .rsp_detect(rsp_detect),
      .busy(busy), .done(done), .fail(fail), .min_size(min_size),
      .first_set(first_set), .set_count(set_count),
      .redundant_count(redundant_count)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   endtask

   // Independent model: brute force over vector masks
   function automatic exp_t model();
      exp_t e;
      int best_key;
      e.size = 0; e.cnt = 0; e.fl = 1; e.first = 0; e.red = 0;
      for (int f = 0; f < NF; f++) if (cols[f] == 0) e.red++;
      for (int k = 1; k <= NL && e.size == 0; k++) begin
         best_key = 1 << 30;
         for (int m = 1; m < (1 << NR); m++) begin
            if ($countones(m) == k) begin
               bit ok = 1;
               for (int f = 0; f < NF; f++)
                  if (cols[f] != 0 && (cols[f] & m[NR-1:0]) == 0) ok = 0;
               if (ok) begin
                  int slot = 0, key = 0, enc = 0;
                  for (int v = 0; v < NR; v++) begin
                     if (m[v]) begin
                        enc = enc | (v << (slot * NL));
                        key = key | (v << ((NL - 1 - slot) * NL));
                        slot++;
                     end
                  end
                  e.cnt++;
                  if (key < best_key) begin best_key = key; e.first = enc; end
               end
            end
         end
         if (e.cnt != 0) begin e.size = k; e.fl = 0; end
      end
      if (e.fl) e.first = 0;
      return e;
   endfunction

   task automatic run_case();
      q.push_back(model());
      ord = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   // Evaluator model with varying latency, also checks request order (R1)
   always @(negedge clk) begin
      if (!rst_n) begin
         rsp_valid = 1'b0;
         wcnt = 0;
      end else if (rsp_valid) begin
         rsp_valid = 1'b0;
         wcnt = ord % 3;
      end else if (req_valid) begin
         if (wcnt == 0) begin
            chk("R1 req_vec", int'(req_vec), (ord / NF) % NR);
            chk("R1 req_fault", int'(req_fault), ord % NF);
            rsp_detect = cols[req_fault][req_vec];
            rsp_valid = 1'b1;
            ord++;
         end else begin
            wcnt--;
         end
      end
   end

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         dones++;
         chk("R7 busy with done", int'(busy), 1);
         if (q.size() == 0) begin
            chk("R7 unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk("R3 min_size", int'(min_size), e.size);
            chk("R4 first_set", int'(first_set), e.first);
            chk("R5 set_count", int'(set_count), e.cnt);
            chk("R2 redundant_count", int'(redundant_count), e.red);
            chk("R6 fail", int'(fail), e.fl);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      chk("watchdog expired", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R8: reset state
      chk("R8 busy", int'(busy), 0);
      chk("R8 done", int'(done), 0);
      chk("R8 req_valid", int'(req_valid), 0);
      chk("R8 fail", int'(fail), 0);
      chk("R8 min_size", int'(min_size), 0);
      chk("R8 set_count", int'(set_count), 0);
      chk("R8 first_set", int'(first_set), 0);
      chk("R8 redundant_count", int'(redundant_count), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // every vector detects every fault: size 1, all eight single sets
      for (int f = 0; f < NF; f++) cols[f] = 8'hFF;
      run_case();

      // halves alternate: needs one low and one high vector (R3, R4, R5)
      for (int f = 0; f < NF; f++) cols[f] = f[0] ? 8'hF0 : 8'h0F;
      run_case();

      // three disjoint groups plus redundant faults: size 3 (R2, R3)
      cols[0] = 8'h03; cols[1] = 8'h0C; cols[2] = 8'hF0; cols[3] = 8'h00;
      cols[4] = 8'h03; cols[5] = 8'h0C; cols[6] = 8'hF0; cols[7] = 8'h00;
      run_case();

      // four disjoint pairs: no cover within three vectors (R6)
      cols[0] = 8'h03; cols[1] = 8'h0C; cols[2] = 8'h30; cols[3] = 8'hC0;
      cols[4] = 8'h00; cols[5] = 8'h00; cols[6] = 8'h00; cols[7] = 8'h03;
      run_case();

      // every fault redundant (R9)
      for (int f = 0; f < NF; f++) cols[f] = 8'h00;
      run_case();
      chk("R9 count all vectors", int'(set_count), NR);

      // start while busy must be ignored (R7)
      cols[0] = 8'h81; cols[1] = 8'h42; cols[2] = 8'h24; cols[3] = 8'h18;
      cols[4] = 8'hC3; cols[5] = 8'h81; cols[6] = 8'h3C; cols[7] = 8'h00;
      q.push_back(model());
      ord = 0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      chk("R7 busy mid run", int'(busy), 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      @(negedge clk);
      repeat (400) @(negedge clk);
      chk("R7 single done per run", dones, 6);
      chk("R7 scoreboard drained", q.size(), 0);
      chk("R7 idle after run", int'(busy), 0);
      finish_run();
   end

endmodule